// File: doc/BRIEF.md
# Serial Zero-Suppressing Display Scanner

This block drives an N-digit, time-multiplexed seven-segment display from one shared segment decoder. A packed BCD value comes in with a digit-rate step strobe. On each step the scanner moves to the next digit, starting from the most significant digit of the frame and working down. It presents that digit's segments together with a one-hot digit select. There are no gap cycles between the segments and the select.

Leading zeros are removed serially. A single carry flip-flop records whether any significant digit has appeared so far in the current frame. That carry is the blanking input for the next slot, so no per-digit decoder chain is needed. The carry is cleared when the scan wraps to the top digit. The lowest digit is always treated as significant, so a value of zero shows a single "0".

Brightness comes from a free-running PWM counter that gates the decoder enable. During the off phase all segments are blanked. A lamp-test input lights every segment.

Top module: `mux_zs_scanner`

## Requirements
- R1: After a synchronous active-low reset, the select is one-hot on the most significant digit (bit NUM_DIGITS-1), the zero carry is cleared and the PWM counter is 0.
- R2: Each cycle with `step_i` high moves the select one position toward bit 0, and from bit 0 it wraps to bit NUM_DIGITS-1. Cycles without a step hold the select. Exactly one select bit is high at all times, and the segments always belong to the selected digit `bcd_i[4k+3:4k]`.
- R3: When lit, a digit is shown with `seg_o` bit 0 = a through bit 6 = g. The patterns are 0→7'h3F, 1→7'h06, 2→7'h5B, 3→7'h4F, 4→7'h66, 5→7'h6D, 6→7'h7C, 7→7'h07, 8→7'h7F, 9→7'h67.
- R4: A zero digit is blanked (seg 0) when every more significant digit already scanned in the same frame was zero.
- R5: A zero digit that follows a nonzero digit in the same frame is shown as "0".
- R6: Digit 0, the least significant, is always shown, even when its value and all digits above it are zero.
- R7: Codes 10 to 15 show a blank digit but count as significant, so zeros after them in the frame are shown.
- R8: The PWM counter is PWM_BITS wide and increments every clock. Segments may light only while counter < `duty_i`, so a duty of 0 blanks the display.
- R9: The zero carry changes only on a step and depends only on the digit values. The PWM phase and lamp test at the step do not change which zeros are suppressed.
- R10: While `lamp_test_i` is high, `seg_o` is 7'h7F whatever the digit, duty or suppression state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Digit-advance strobe, one cycle per digit slot |
| bcd_i | input | 4*NUM_DIGITS | Packed BCD value, digit k at bits 4k+3:4k, digit 0 least significant |
| duty_i | input | PWM_BITS | Intensity: on-cycles per PWM period |
| lamp_test_i | input | 1 | Light all segments |
| seg_o | output | 7 | Segments, bit 0 = a ... bit 6 = g, active high |
| sel_o | output | NUM_DIGITS | One-hot digit select |

## Verification
Several kinds of values are scanned through whole frames: all digits nonzero, leading zeros of different lengths, embedded zeros after a significant digit, an all-zero value, and illegal codes in the upper digits. These runs separate the suppression rule from plain decoding, and they show whether the carry is cleared at each frame wrap. Step spacing is varied from back-to-back steps to long gaps, which tests the hold and wrap of the select. Duty values of 0, 1, mid and full are run while steps land in both PWM phases. A lamp-test burst across steps follows, and the frames after it show that neither PWM nor lamp test disturbs suppression.

// File: rtl/zs_pkg.sv
// Shared types and glyph table for the zero-suppressing display scanner.
// Assumes segment order bit0=a .. bit6=g, active high.
package zs_pkg;

    typedef logic [6:0] seg_t;

    localparam seg_t SEG_ALL_ON  = 7'h7F;
    localparam seg_t SEG_ALL_OFF = 7'h00;
    localparam int   BCD_W       = 4;

    // Glyph for one decimal code; illegal codes give a blank pattern.
    function automatic seg_t glyph_of(input logic [BCD_W-1:0] code);
        seg_t g;
        case (code)
            4'd0:    g = 7'h3F;
            4'd1:    g = 7'h06;
            4'd2:    g = 7'h5B;
            4'd3:    g = 7'h4F;
            4'd4:    g = 7'h66;
            4'd5:    g = 7'h6D;
            4'd6:    g = 7'h7C;
            4'd7:    g = 7'h07;
            4'd8:    g = 7'h7F;
            4'd9:    g = 7'h67;
            default: g = SEG_ALL_OFF;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/zs_pwm_gen.sv
// Intensity generator: a free-running counter of PWM_BITS bits compared
// against the duty value. lit_o is high while count < duty, so a duty of 0
// never lights. Assumes duty_i is quasi-static relative to the period.
module zs_pwm_gen #(
    parameter int unsigned PWM_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PWM_BITS-1:0] duty_i,
    output logic                lit_o
);

    logic [PWM_BITS-1:0] cnt_q;

    // Free-running phase counter, wraps naturally at 2**PWM_BITS.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // On phase while the counter is below the duty value.
    always_comb lit_o = (cnt_q < duty_i);

endmodule

// File: rtl/zs_digit_scan.sv
// Digit scan sequencer: holds the current digit index, starting at the
// most significant digit and moving down one slot per step, wrapping from
// digit 0 back to the top. Produces the one-hot select from the same
// register so select and digit data change together.
// Assumes NUM_DIGITS >= 2.
module zs_digit_scan #(
    parameter int unsigned NUM_DIGITS = 4,
    localparam int unsigned IDX_W     = $clog2(NUM_DIGITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_i,
    output logic [IDX_W-1:0]      idx_o,
    output logic                  last_o,
    output logic [NUM_DIGITS-1:0] sel_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_DIGITS - 1);

    logic [IDX_W-1:0] idx_q;

    // Advance toward digit 0 on each step, wrapping to the top digit.
    always_ff @(posedge clk) begin
        if (!rst_n)           idx_q <= TOP_IDX;
        else if (step_i) begin
            if (idx_q == '0)  idx_q <= TOP_IDX;
            else              idx_q <= idx_q - 1'b1;
        end
    end

    // One select line per digit, decoded from the index.
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
        assign sel_o[g] = (idx_q == IDX_W'(g));
    end

    // Index and end-of-frame flag for the neighbours.
    always_comb begin
        idx_o  = idx_q;
        last_o = (idx_q == '0);
    end

endmodule

// File: rtl/zs_blank_carry.sv
// Serial ripple-blanking store: one flip-flop that remembers whether a
// significant digit has been scanned in the current frame. It is cleared
// when the scan leaves digit 0 and set by a nonzero code on a step. The
// blanking input for the current slot is forced high on digit 0.
// Assumes code_nz_i reflects only digit data (not PWM or lamp test).
module zs_blank_carry (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic last_i,
    input  logic code_nz_i,
    output logic rbi_o
);

    logic carry_q;

    // Capture significance on step; clear at the frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)          carry_q <= 1'b0;
        else if (step_i) begin
            if (last_i)      carry_q <= 1'b0;
            else             carry_q <= carry_q | code_nz_i;
        end
    end

    // Blanking input for the slot now on display.
    always_comb rbi_o = carry_q | last_i;

endmodule

// File: rtl/zs_seg_decoder.sv
// Seven-segment decoder with enable and ripple-blanking input.
// en=0,rbi=0: all segments on (lamp test). en=0,rbi=1: blank.
// en=1: zero is blanked unless rbi=1; 1..9 always drawn; 10..15 blank.
module zs_seg_decoder
    import zs_pkg::*;
(
    input  logic             en_i,
    input  logic             rbi_i,
    input  logic [BCD_W-1:0] code_i,
    output seg_t             seg_o
);

    // Pick the segment pattern from the auxiliary controls and the code.
    always_comb begin
        if (!en_i && !rbi_i)              seg_o = SEG_ALL_ON;
        else if (!en_i)                   seg_o = SEG_ALL_OFF;
        else if (code_i == '0 && !rbi_i)  seg_o = SEG_ALL_OFF;
        else                              seg_o = glyph_of(code_i);
    end

endmodule

// File: rtl/mux_zs_scanner.sv
// Top of the multiplexed display scanner. Selects the current digit from
// the packed BCD value, drives one shared decoder, and carries the
// zero-suppression state serially across slots. PWM gates the decoder
// enable with blanking-in held high; lamp test drives both low.
// Assumes step_i is a single-cycle strobe at digit rate.
module mux_zs_scanner
    import zs_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 4,
    parameter int unsigned PWM_BITS   = 4,
    localparam int unsigned IDX_W     = $clog2(NUM_DIGITS),
    localparam int unsigned VAL_W     = BCD_W * NUM_DIGITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_i,
    input  logic [VAL_W-1:0]      bcd_i,
    input  logic [PWM_BITS-1:0]   duty_i,
    input  logic                  lamp_test_i,
    output logic [6:0]            seg_o,
    output logic [NUM_DIGITS-1:0] sel_o
);

    logic [IDX_W-1:0] idx;
    logic             last;
    logic             lit;
    logic             rbi_chain;
    logic [BCD_W-1:0] code;
    logic             dec_en;
    logic             dec_rbi;
    seg_t             dec_seg;

    zs_digit_scan #(.NUM_DIGITS(NUM_DIGITS)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_i),
        .idx_o  (idx),
        .last_o (last),
        .sel_o  (sel_o)
    );

    zs_pwm_gen #(.PWM_BITS(PWM_BITS)) u_pwm (
        .clk    (clk),
        .rst_n  (rst_n),
        .duty_i (duty_i),
        .lit_o  (lit)
    );

    // Digit multiplexer: nibble of the slot now being scanned.
    always_comb begin
        code = '0;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            if (idx == IDX_W'(k)) code = bcd_i[k*BCD_W +: BCD_W];
        end
    end

    zs_blank_carry u_carry (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_i),
        .last_i    (last),
        .code_nz_i (code != '0),
        .rbi_o     (rbi_chain)
    );

    // Decoder control: lamp test, then PWM off phase, then normal display.
    always_comb begin
        if (lamp_test_i) begin
            dec_en  = 1'b0;
            dec_rbi = 1'b0;
        end else if (!lit) begin
            dec_en  = 1'b0;
            dec_rbi = 1'b1;
        end else begin
            dec_en  = 1'b1;
            dec_rbi = rbi_chain;
        end
    end

    zs_seg_decoder u_dec (
        .en_i   (dec_en),
        .rbi_i  (dec_rbi),
        .code_i (code),
        .seg_o  (dec_seg)
    );

    assign seg_o = dec_seg;

endmodule

// File: rtl/zs_scanner_checker.sv
// Port-level properties of the scanner, bound onto every instance of it.
module zs_scanner_checker #(
    parameter int unsigned NUM_DIGITS = 4,
    parameter int unsigned PWM_BITS   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  step_i,
    input logic [PWM_BITS-1:0]   duty_i,
    input logic                  lamp_test_i,
    input logic [6:0]            seg_o,
    input logic [NUM_DIGITS-1:0] sel_o
);

    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_o) == 1);

    a_r2_step_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !sel_o[0]) |=> (sel_o == ($past(sel_o) >> 1)));

    a_r2_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && sel_o[0]) |=> sel_o[NUM_DIGITS-1]);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(sel_o));

    a_r8_duty_zero_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_i == '0 && !lamp_test_i) |-> (seg_o == 7'h00));

    a_r10_lamp_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_test_i |-> (seg_o == 7'h7F));

endmodule

bind mux_zs_scanner zs_scanner_checker #(
    .NUM_DIGITS (NUM_DIGITS),
    .PWM_BITS   (PWM_BITS)
) u_zs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .duty_i      (duty_i),
    .lamp_test_i (lamp_test_i),
    .seg_o       (seg_o),
    .sel_o       (sel_o)
);

// File: tb/mux_zs_scanner_bench.sv
module mux_zs_scanner_bench;

    localparam int N  = 4;
    localparam int PB = 4;
    localparam int PERIOD_CNT = 1 << PB;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            step = 1'b0;
    logic [4*N-1:0]  bcd = '0;
    logic [PB-1:0]   duty = '0;
    logic            lamp = 1'b0;
    logic [6:0]      seg;
    logic [N-1:0]    sel;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    checking = 1'b0;
    string tag = "R1";

    // Reference model state.
    int m_idx   = N - 1;
    int m_carry = 0;
    int m_pwm   = 0;

    always #4 clk = ~clk;

    mux_zs_scanner #(.NUM_DIGITS(N), .PWM_BITS(PB)) u_mux_zs_scanner (
        .clk(clk), .rst_n(rst_n), .step_i(step), .bcd_i(bcd),
        .duty_i(duty), .lamp_test_i(lamp), .seg_o(seg), .sel_o(sel)
    );

    function automatic logic [6:0] glyph(input int v);
        case (v)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
            3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
            6: return 7'h7C;  7: return 7'h07;  8: return 7'h7F;
            9: return 7'h67;  default: return 7'h00;
        endcase
    endfunction

    function automatic int digit_at(input int k);
        return int'((bcd >> (4 * k)) & 4'hF);
    endfunction

    // Model update at each edge, mirroring the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = N - 1; m_carry = 0; m_pwm = 0;
        end else begin
            if (step) begin
                if (m_idx == 0) begin
                    m_idx = N - 1; m_carry = 0;
                end else begin
                    if (digit_at(m_idx) != 0) m_carry = 1;
                    m_idx = m_idx - 1;
                end
            end
            m_pwm = (m_pwm + 1) % PERIOD_CNT;
        end
    end

    // Compare outputs mid-cycle.
    always @(negedge clk) begin
        if (checking) begin
            logic [6:0]   e_seg;
            logic [N-1:0] e_sel;
            int code;
            bit shown;
            code  = digit_at(m_idx);
            shown = (m_idx == 0) || (m_carry != 0) || (code != 0);
            if (lamp)                 e_seg = 7'h7F;
            else if (m_pwm >= duty)   e_seg = 7'h00;
            else if (!shown)          e_seg = 7'h00;
            else                      e_seg = glyph(code);
            e_sel = N'(1) << m_idx;
            checks++;
            if (seg !== e_seg) begin
                errors++;
                $display("FAIL %s seg got %h exp %h (digit %0d code %0d)", tag, seg, e_seg, m_idx, code);
            end
            checks++;
            if (sel !== e_sel) begin
                errors++;
                $display("FAIL %s sel got %b exp %b", tag, sel, e_sel);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run(input logic [4*N-1:0] v, input int d, input bit lt,
                       input int frames, input int gap);
        @(posedge clk); #1;
        step = 1'b0; bcd = v; duty = PB'(d); lamp = lt;
        for (int f = 0; f < frames; f++) begin
            for (int k = 0; k < N; k++) begin
                repeat (gap) begin @(posedge clk); #1; step = 1'b0; end
                @(posedge clk); #1; step = 1'b1;
            end
        end
        @(posedge clk); #1; step = 1'b0;
    endtask

    initial begin
        duty = PB'(15);
        repeat (2) @(posedge clk);
        checking = 1'b1;               // R1: reset state observed here
        repeat (2) @(posedge clk);
        #1; rst_n = 1'b1;
        repeat (3) @(posedge clk);

        tag = "R3";  run(16'h1234, 15, 0, 2, 3);
                     run(16'h5678, 15, 0, 2, 3);
                     run(16'h9999, 15, 0, 1, 2);
        tag = "R2";  run(16'h4321, 15, 0, 3, 0);
                     run(16'h8765, 15, 0, 2, 5);
        tag = "R4";  run(16'h0007, 15, 0, 2, 3);
                     run(16'h0040, 15, 0, 2, 3);
                     run(16'h0305, 15, 0, 2, 2);
        tag = "R5";  run(16'h9090, 15, 0, 2, 3);
                     run(16'h1000, 15, 0, 2, 3);
        tag = "R6";  run(16'h0000, 15, 0, 2, 3);
        tag = "R7";  run(16'h0A00, 15, 0, 2, 3);
                     run(16'hF000, 15, 0, 2, 3);
                     run(16'h00C0, 15, 0, 2, 3);
        tag = "R8";  run(16'h8888, 0, 0, 2, 7);
                     run(16'h8888, 1, 0, 2, 9);
                     run(16'h0808, 8, 0, 3, 11);
        tag = "R9";  run(16'h0102, 2, 0, 4, 6);
                     run(16'h0030, 5, 0, 4, 5);
        tag = "R10"; run(16'h0000, 0, 1, 2, 3);
                     run(16'h0905, 9, 1, 2, 4);
        tag = "R9";  run(16'h0000, 15, 0, 2, 3);
                     run(16'h0400, 15, 0, 2, 3);
        tag = "R1";
        @(posedge clk); #1; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1; rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checking = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule